// File: doc/BRIEF.md
# Multicycle 32-bit Processor Datapath

This block is the datapath of a 32-bit processor that runs each instruction over several clock cycles. One memory port serves both instruction fetch and data access. One ALU does every addition, subtraction, logic operation and comparison, including the PC increment and the branch-target sum. Registers placed between the major units carry values from one cycle to the next:

- the program counter;
- the instruction register;
- the memory data register;
- two operand registers;
- an ALU result register.

There is also a 32-entry register file.

A separate control state machine drives every enable and select of the datapath, one cycle at a time. The datapath returns the opcode and function fields of the held instruction so that the state machine can pick its next state. The memory on the other side returns read data in the same cycle as the address and takes writes at the clock edge.

A typical sequence is as follows. A fetch cycle latches the instruction and adds four to the PC. A decode cycle reads both source registers and precomputes a branch target. After that comes one of these:

- an address, ALU or compare cycle;
- a memory or register-write cycle;
- for loads only, a final write-back cycle.

Top module: `mc_datapath`

## Requirements
- R1: While reset is held, and for the two clock edges after `rst_n` rises, the PC and all holding registers (IR, MDR, A, B, ALUOut) and every register-file entry are zero. Right after release, `mem_addr`, `mem_wdata`, `op_code` and `fn_code` read zero.
- R2: Fetch (ctl_mem_rd, ctl_ir_we, ctl_pc_we, ctl_srca_a=0, ctl_srcb=1 giving constant 4, ctl_alu_op=2 ADD, ctl_pc_src=0 ALU result): at one edge the IR takes the word at the PC, and the PC becomes PC+4.
- R3: With ctl_a_we/ctl_b_we, A takes register IR[25:21] and B takes register IR[20:16]. With ctl_srcb=3, ctl_srca_a=0 and ADD, ALUOut takes PC plus the sign-extended IR[15:0] shifted left by two.
- R4: With ctl_srca_a=1, ctl_srcb=2 and ADD, ALUOut takes A plus the sign-extended IR[15:0]. With ctl_addr_alu=1 the memory address is ALUOut; otherwise it is the PC.
- R5: With ctl_srca_a=1 and ctl_srcb=0, ALUOut takes A op B, where ctl_alu_op selects 0 AND, 1 OR, 2 ADD, 3 XOR, 4 NOR, 5 unsigned less-than, 6 SUB, 7 signed less-than. The comparisons give 1 or 0.
- R6: With ctl_pc_cond, SUB on A and B, and ctl_pc_src=1, the PC takes ALUOut only when A equals B. Otherwise the PC keeps its value.
- R7: With ctl_pc_we and ctl_pc_src=2, the PC takes the top four PC bits, then IR[25:0], then two zero bits.
- R8: With ctl_mdr_we the MDR takes the read data. With ctl_rf_we, ctl_wb_mdr=1 and ctl_dst_rd=0, the MDR is written to register IR[20:16].
- R9: `mem_wdata` is always B. `mem_wr` and `mem_rd` follow the control inputs, so a store writes B to the word at ALUOut.
- R10: With ctl_rf_we, ctl_wb_mdr=0 and ctl_dst_rd=1, ALUOut is written to register IR[15:11] at the edge that ends the cycle, and a read in the next cycle sees it.
- R11: Register 0 always reads as zero, and writes to it are ignored.
- R12: The PC, IR, MDR, A, B, ALUOut and the register file keep their values in any cycle where their own enable is low.
- R13: `op_code` is IR[31:26] and `fn_code` is IR[5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_pc_we | input | 1 | Unconditional PC write |
| ctl_pc_cond | input | 1 | PC write when the ALU result is zero |
| ctl_pc_src | input | 2 | PC source: 0 ALU result, 1 ALUOut, 2 jump target, 3 ALU result |
| ctl_addr_alu | input | 1 | Memory address from ALUOut instead of the PC |
| ctl_mem_rd | input | 1 | Memory read request |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_ir_we | input | 1 | IR load enable |
| ctl_mdr_we | input | 1 | MDR load enable |
| ctl_a_we | input | 1 | A load enable |
| ctl_b_we | input | 1 | B load enable |
| ctl_alo_we | input | 1 | ALUOut load enable |
| ctl_srca_a | input | 1 | ALU first operand: 0 PC, 1 A |
| ctl_srcb | input | 2 | ALU second operand: 0 B, 1 four, 2 sign-extended imm, 3 same shifted by two |
| ctl_alu_op | input | 3 | ALU operation code (see R5) |
| ctl_rf_we | input | 1 | Register-file write enable |
| ctl_dst_rd | input | 1 | Write index: 0 IR[20:16], 1 IR[15:11] |
| ctl_wb_mdr | input | 1 | Write data: 0 ALUOut, 1 MDR |
| op_code | output | 6 | IR[31:26] to the control FSM |
| fn_code | output | 6 | IR[5:0] to the control FSM |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the addressed cycle |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |

## Verification
Every holding register changes at the edge that ends the cycle in which its enable was raised. So the memory address, write data and opcode fields show a cycle's effect one clock later, and a register-file write shows up one cycle after its write cycle, when a decode reads it. The reference model in the bench advances its state at each rising edge from the controls the bench drove. It compares the design's outputs midway through the low phase, after the new controls have settled, against its state and the current selects. It does not check before the two-edge reset release has elapsed. Branches and jumps are judged from the address shown during the next fetch, and every ALU result is judged from the data written by a later store.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    ALU_AND  = 3'd0,
    ALU_OR   = 3'd1,
    ALU_ADD  = 3'd2,
    ALU_XOR  = 3'd3,
    ALU_NOR  = 3'd4,
    ALU_SLTU = 3'd5,
    ALU_SUB  = 3'd6,
    ALU_SLT  = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG    = 2'd0,
    SRCB_FOUR   = 2'd1,
    SRCB_IMM    = 2'd2,
    SRCB_IMM_SH = 2'd3
  } srcb_e;

  typedef enum logic [1:0] {
    PCSRC_ALU    = 2'd0,
    PCSRC_ALUOUT = 2'd1,
    PCSRC_JUMP   = 2'd2,
    PCSRC_ALU_B  = 2'd3
  } pcsrc_e;

  localparam int OP_HI  = 31;
  localparam int OP_LO  = 26;
  localparam int RS_HI  = 25;
  localparam int RS_LO  = 21;
  localparam int RT_HI  = 20;
  localparam int RT_LO  = 16;
  localparam int RD_HI  = 15;
  localparam int RD_LO  = 11;
  localparam int IMM_W  = 16;
  localparam int JMP_W  = 26;
  localparam int FN_W   = 6;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1
);

  logic [W-1:0] regs_q [N];
  logic         wr_hit;

  assign wr_hit = we && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        regs_q[i] <= '0;
      end
    end else if (wr_hit) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rd0 = (ra0 == '0) ? '0 : regs_q[ra0];
  assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   op,
  output logic [W-1:0] res,
  output logic         zero
);

  logic [W-1:0] diff;
  logic         lt_s;
  logic         lt_u;

  assign diff = opa - opb;
  assign lt_s = $signed(opa) < $signed(opb);
  assign lt_u = opa < opb;

  always_comb begin
    case (alu_op_e'(op))
      ALU_AND:  res = opa & opb;
      ALU_OR:   res = opa | opb;
      ALU_ADD:  res = opa + opb;
      ALU_XOR:  res = opa ^ opb;
      ALU_NOR:  res = ~(opa | opb);
      ALU_SLTU: res = {{(W-1){1'b0}}, lt_u};
      ALU_SUB:  res = diff;
      ALU_SLT:  res = {{(W-1){1'b0}}, lt_s};
      default:  res = opa + opb;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int REG_N       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int RAW        = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_pc_we,
  input  logic              ctl_pc_cond,
  input  logic [1:0]        ctl_pc_src,
  input  logic              ctl_addr_alu,
  input  logic              ctl_mem_rd,
  input  logic              ctl_mem_wr,
  input  logic              ctl_ir_we,
  input  logic              ctl_mdr_we,
  input  logic              ctl_a_we,
  input  logic              ctl_b_we,
  input  logic              ctl_alo_we,
  input  logic              ctl_srca_a,
  input  logic [1:0]        ctl_srcb,
  input  logic [2:0]        ctl_alu_op,
  input  logic              ctl_rf_we,
  input  logic              ctl_dst_rd,
  input  logic              ctl_wb_mdr,
  output logic [5:0]        op_code,
  output logic [5:0]        fn_code,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr
);

  localparam int PC_TOP = 4;

  logic              rst_q_n;

  logic [DATA_W-1:0] pc_q,  pc_d;
  logic [DATA_W-1:0] ir_q,  ir_d;
  logic [DATA_W-1:0] mdr_q, mdr_d;
  logic [DATA_W-1:0] a_q,   a_d;
  logic [DATA_W-1:0] b_q,   b_d;
  logic [DATA_W-1:0] alo_q, alo_d;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] jump_tgt;
  logic [DATA_W-1:0] src_a;
  logic [DATA_W-1:0] src_b;
  logic [DATA_W-1:0] alu_res;
  logic              alu_zero;
  logic [DATA_W-1:0] pc_next;
  logic              pc_load;

  logic [RAW-1:0]    rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  logic [DATA_W-1:0] rf_rd0;
  logic [DATA_W-1:0] rf_rd1;

  mc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  mc_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (ctl_rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra0   (ir_q[RS_HI:RS_LO]),
    .ra1   (ir_q[RT_HI:RT_LO]),
    .rd0   (rf_rd0),
    .rd1   (rf_rd1)
  );

  mc_alu #(.W(DATA_W)) u_alu (
    .opa  (src_a),
    .opb  (src_b),
    .op   (ctl_alu_op),
    .res  (alu_res),
    .zero (alu_zero)
  );

  // Operand and target formation
  assign imm_ext  = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign jump_tgt = {pc_q[DATA_W-1 -: PC_TOP], ir_q[JMP_W-1:0], 2'b00};
  assign src_a    = ctl_srca_a ? a_q : pc_q;

  always_comb begin
    case (srcb_e'(ctl_srcb))
      SRCB_REG:    src_b = b_q;
      SRCB_FOUR:   src_b = DATA_W'(4);
      SRCB_IMM:    src_b = imm_ext;
      SRCB_IMM_SH: src_b = {imm_ext[DATA_W-3:0], 2'b00};
      default:     src_b = b_q;
    endcase
  end

  always_comb begin
    case (pcsrc_e'(ctl_pc_src))
      PCSRC_ALU:    pc_next = alu_res;
      PCSRC_ALUOUT: pc_next = alo_q;
      PCSRC_JUMP:   pc_next = jump_tgt;
      default:      pc_next = alu_res;
    endcase
  end

  assign pc_load  = ctl_pc_we | (ctl_pc_cond & alu_zero);
  assign rf_waddr = ctl_dst_rd ? ir_q[RD_HI:RD_LO] : ir_q[RT_HI:RT_LO];
  assign rf_wdata = ctl_wb_mdr ? mdr_q : alo_q;

  // Next-state of the holding registers
  always_comb begin
    pc_d  = pc_q;
    ir_d  = ir_q;
    mdr_d = mdr_q;
    a_d   = a_q;
    b_d   = b_q;
    alo_d = alo_q;
    if (pc_load)    pc_d  = pc_next;
    if (ctl_ir_we)  ir_d  = mem_rdata;
    if (ctl_mdr_we) mdr_d = mem_rdata;
    if (ctl_a_we)   a_d   = rf_rd0;
    if (ctl_b_we)   b_d   = rf_rd1;
    if (ctl_alo_we) alo_d = alu_res;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alo_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      mdr_q <= mdr_d;
      a_q   <= a_d;
      b_q   <= b_d;
      alo_q <= alo_d;
    end
  end

  // Outputs
  assign op_code   = ir_q[OP_HI:OP_LO];
  assign fn_code   = ir_q[FN_W-1:0];
  assign mem_addr  = ctl_addr_alu ? alo_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd    = ctl_mem_rd;
  assign mem_wr    = ctl_mem_wr;

endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk
  import mc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              ctl_pc_we,
  input logic              ctl_pc_cond,
  input logic [1:0]        ctl_pc_src,
  input logic              ctl_srca_a,
  input logic [1:0]        ctl_srcb,
  input logic [2:0]        ctl_alu_op,
  input logic              ctl_ir_we,
  input logic              ctl_mdr_we,
  input logic              ctl_a_we,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] pc_q,
  input logic [DATA_W-1:0] ir_q,
  input logic [DATA_W-1:0] mdr_q,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] b_q,
  input logic [DATA_W-1:0] alo_q
);

  logic fetch_step;
  logic branch_cmp;

  assign fetch_step = ctl_pc_we && (ctl_pc_src == PCSRC_ALU) && !ctl_srca_a &&
                      (ctl_srcb == SRCB_FOUR) && (ctl_alu_op == ALU_ADD);
  assign branch_cmp = ctl_pc_cond && !ctl_pc_we && (ctl_pc_src == PCSRC_ALUOUT) &&
                      ctl_srca_a && (ctl_srcb == SRCB_REG) && (ctl_alu_op == ALU_SUB);

  p_ir_load_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctl_ir_we |=> ir_q == $past(mem_rdata));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    fetch_step |=> pc_q == $past(pc_q) + DATA_W'(4));

  p_branch_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    branch_cmp |=> pc_q == (($past(a_q) == $past(b_q)) ? $past(alo_q) : $past(pc_q)));

  p_jump_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_pc_we && ctl_pc_src == PCSRC_JUMP) |=>
      pc_q == {$past(pc_q[DATA_W-1 -: 4]), $past(ir_q[JMP_W-1:0]), 2'b00});

  p_mdr_load_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctl_mdr_we |=> mdr_q == $past(mem_rdata));

  p_zero_read_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_a_we && ir_q[RS_HI:RS_LO] == '0) |=> a_q == '0);

  p_hold_pc_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ctl_pc_we && !ctl_pc_cond) |=> $stable(pc_q));

  p_hold_ir_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ctl_ir_we |=> $stable(ir_q));

  p_hold_a_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ctl_a_we |=> $stable(a_q));

endmodule

bind mc_datapath mc_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .ctl_pc_we   (ctl_pc_we),
  .ctl_pc_cond (ctl_pc_cond),
  .ctl_pc_src  (ctl_pc_src),
  .ctl_srca_a  (ctl_srca_a),
  .ctl_srcb    (ctl_srcb),
  .ctl_alu_op  (ctl_alu_op),
  .ctl_ir_we   (ctl_ir_we),
  .ctl_mdr_we  (ctl_mdr_we),
  .ctl_a_we    (ctl_a_we),
  .mem_rdata   (mem_rdata),
  .pc_q        (pc_q),
  .ir_q        (ir_q),
  .mdr_q       (mdr_q),
  .a_q         (a_q),
  .b_q         (b_q),
  .alo_q       (alo_q)
);

// File: tb/mc_datapath_test.sv
`timescale 1ns/1ps
module mc_datapath_test;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_pc_we, ctl_pc_cond, ctl_addr_alu, ctl_mem_rd, ctl_mem_wr;
  logic ctl_ir_we, ctl_mdr_we, ctl_a_we, ctl_b_we, ctl_alo_we, ctl_srca_a;
  logic ctl_rf_we, ctl_dst_rd, ctl_wb_mdr;
  logic [1:0] ctl_pc_src, ctl_srcb;
  logic [2:0] ctl_alu_op;
  logic [5:0] op_code, fn_code;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_rd, mem_wr;

  logic [31:0] mem   [256];
  logic [31:0] m_mem [256];
  logic [31:0] m_rf  [32];
  logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_alo;
  int checks = 0;
  int errors = 0;
  int rel = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  string phase = "R1";

  always #HALF clk = ~clk;

  mc_datapath uut (
    .clk(clk), .rst_n(rst_n), .ctl_pc_we(ctl_pc_we), .ctl_pc_cond(ctl_pc_cond),
    .ctl_pc_src(ctl_pc_src), .ctl_addr_alu(ctl_addr_alu), .ctl_mem_rd(ctl_mem_rd),
    .ctl_mem_wr(ctl_mem_wr), .ctl_ir_we(ctl_ir_we), .ctl_mdr_we(ctl_mdr_we),
    .ctl_a_we(ctl_a_we), .ctl_b_we(ctl_b_we), .ctl_alo_we(ctl_alo_we),
    .ctl_srca_a(ctl_srca_a), .ctl_srcb(ctl_srcb), .ctl_alu_op(ctl_alu_op),
    .ctl_rf_we(ctl_rf_we), .ctl_dst_rd(ctl_dst_rd), .ctl_wb_mdr(ctl_wb_mdr),
    .op_code(op_code), .fn_code(fn_code), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  // Memory seen by the design: same-cycle read, write at the edge
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr === 1'b1) mem[mem_addr[9:2]] <= mem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] sext(logic [31:0] w);
    return {{16{w[15]}}, w[15:0]};
  endfunction
  function automatic logic [31:0] ref_alu(logic [2:0] op, logic [31:0] x, logic [31:0] y);
    case (op)
      3'd0: return x & y;
      3'd1: return x | y;
      3'd2: return x + y;
      3'd3: return x ^ y;
      3'd4: return ~(x | y);
      3'd5: return (x < y) ? 32'd1 : 32'd0;
      3'd6: return x - y;
      default: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic model_clear();
    m_pc = 0; m_ir = 0; m_mdr = 0; m_a = 0; m_b = 0; m_alo = 0;
    for (int i = 0; i < 32; i++) m_rf[i] = 0;
  endtask

  // Behavioural reference: one step per rising edge
  always @(posedge clk) begin
    logic [31:0] sa, sb, y, ad, npc, na, nb, wd;
    logic [4:0] wa;
    if (!rst_n) begin
      rel = 0; model_clear();
    end else if (rel < 2) begin
      rel++; model_clear();
    end else begin
      sa = ctl_srca_a ? m_a : m_pc;
      case (ctl_srcb)
        2'd0: sb = m_b;
        2'd1: sb = 32'd4;
        2'd2: sb = sext(m_ir);
        default: sb = sext(m_ir) << 2;
      endcase
      y   = ref_alu(ctl_alu_op, sa, sb);
      ad  = ctl_addr_alu ? m_alo : m_pc;
      na  = m_rf[m_ir[25:21]];
      nb  = m_rf[m_ir[20:16]];
      wa  = ctl_dst_rd ? m_ir[15:11] : m_ir[20:16];
      wd  = ctl_wb_mdr ? m_mdr : m_alo;
      npc = m_pc;
      if (ctl_pc_we || (ctl_pc_cond && y == 0)) begin
        case (ctl_pc_src)
          2'd1: npc = m_alo;
          2'd2: npc = {m_pc[31:28], m_ir[25:0], 2'b00};
          default: npc = y;
        endcase
      end
      if (ctl_mdr_we) m_mdr = m_mem[ad[9:2]];
      if (ctl_ir_we)  m_ir  = m_mem[ad[9:2]];
      if (ctl_mem_wr) m_mem[ad[9:2]] = m_b;
      if (ctl_a_we)   m_a   = na;
      if (ctl_b_we)   m_b   = nb;
      if (ctl_alo_we) m_alo = y;
      if (ctl_rf_we && wa != 0) m_rf[wa] = wd;
      m_pc = npc;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare mid low phase, after this cycle's controls have settled
  always @(negedge clk) begin
    #2;
    if (cmp_on && !done) begin
      chk(mem_addr, ctl_addr_alu ? m_alo : m_pc, phase, "mem_addr");
      chk(mem_wdata, m_b, phase, "mem_wdata");
      chk({26'd0, op_code}, {26'd0, m_ir[31:26]}, "R13", "op_code");
      chk({26'd0, fn_code}, {26'd0, m_ir[5:0]}, "R13", "fn_code");
    end
  end

  task automatic idle();
    ctl_pc_we = 0; ctl_pc_cond = 0; ctl_pc_src = 0; ctl_addr_alu = 0;
    ctl_mem_rd = 0; ctl_mem_wr = 0; ctl_ir_we = 0; ctl_mdr_we = 0;
    ctl_a_we = 0; ctl_b_we = 0; ctl_alo_we = 0; ctl_srca_a = 0;
    ctl_srcb = 0; ctl_alu_op = 3'd2; ctl_rf_we = 0; ctl_dst_rd = 0; ctl_wb_mdr = 0;
  endtask
  task automatic cyc(); @(negedge clk); endtask

  task automatic fetch_decode();
    idle(); phase = "R2";
    ctl_mem_rd = 1; ctl_ir_we = 1; ctl_srcb = 2'd1; ctl_pc_we = 1; cyc();
    idle(); phase = "R3";
    ctl_a_we = 1; ctl_b_we = 1; ctl_srcb = 2'd3; ctl_alo_we = 1; cyc();
  endtask
  task automatic addr_calc();
    idle(); phase = "R4"; ctl_srca_a = 1; ctl_srcb = 2'd2; ctl_alo_we = 1; cyc();
  endtask
  task automatic run_lw();
    fetch_decode(); addr_calc();
    idle(); phase = "R8"; ctl_addr_alu = 1; ctl_mem_rd = 1; ctl_mdr_we = 1; cyc();
    idle(); phase = "R8"; ctl_rf_we = 1; ctl_wb_mdr = 1; cyc();
  endtask
  task automatic run_sw();
    fetch_decode(); addr_calc();
    idle(); phase = "R9"; ctl_addr_alu = 1; ctl_mem_wr = 1; cyc();
  endtask
  task automatic run_r(input logic [2:0] op);
    fetch_decode();
    idle(); phase = "R5"; ctl_srca_a = 1; ctl_alu_op = op; ctl_alo_we = 1; cyc();
    idle(); phase = "R10"; ctl_rf_we = 1; ctl_dst_rd = 1; cyc();
  endtask
  task automatic run_beq();
    fetch_decode();
    idle(); phase = "R6"; ctl_srca_a = 1; ctl_alu_op = 3'd6; ctl_pc_cond = 1; ctl_pc_src = 2'd1; cyc();
  endtask
  task automatic run_j();
    fetch_decode();
    idle(); phase = "R7"; ctl_pc_we = 1; ctl_pc_src = 2'd2; cyc();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(2 * HALF * 50000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] va, vb;
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    mem[0]  = enc_i(35, 0, 2, 64);
    mem[1]  = enc_i(35, 0, 3, 68);
    mem[2]  = enc_r(2, 3, 4, 32);
    mem[3]  = enc_r(2, 3, 5, 34);
    mem[4]  = enc_r(2, 3, 6, 42);
    mem[5]  = enc_r(2, 3, 7, 43);
    mem[6]  = enc_r(2, 3, 8, 38);
    mem[7]  = enc_r(2, 3, 9, 39);
    mem[8]  = enc_r(2, 3, 10, 36);
    mem[9]  = enc_r(2, 3, 11, 37);
    mem[10] = enc_r(2, 3, 0, 32);
    mem[11] = enc_r(0, 3, 12, 32);
    mem[12] = enc_i(4, 2, 3, 5);
    mem[13] = enc_i(4, 4, 4, 1);
    mem[14] = enc_i(43, 0, 2, 200);
    mem[15] = {6'd2, 26'd22};
    mem[16] = 32'hFFFF_FFF0;
    mem[17] = 32'h0000_0007;
    for (int k = 0; k < 10; k++)
      mem[22 + k] = enc_i(43, 0, (k == 0) ? 0 : ((k == 9) ? 12 : k + 3), 128 + 4 * k);
    for (int i = 0; i < 256; i++) m_mem[i] = mem[i];

    idle();
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1: reset state seen at the ports right after release
    chk(mem_addr, 32'd0, "R1", "mem_addr after reset");
    chk(mem_wdata, 32'd0, "R1", "mem_wdata after reset");
    chk({26'd0, op_code}, 32'd0, "R1", "op_code after reset");
    chk({26'd0, fn_code}, 32'd0, "R1", "fn_code after reset");
    repeat (2) cyc();
    cmp_on = 1'b1;

    run_lw(); run_lw();
    run_r(3'd2); run_r(3'd6); run_r(3'd7); run_r(3'd5);
    run_r(3'd3); run_r(3'd4); run_r(3'd0); run_r(3'd1);
    run_r(3'd2);               // R11: destination register 0
    run_r(3'd2);               // R11: source register 0
    run_beq();                 // R6: not equal, falls through
    run_beq();                 // R6: equal, skips the store at 56
    run_j();                   // R7: jump to byte 88
    for (int k = 0; k < 10; k++) run_sw();
    idle(); repeat (2) cyc();

    va = 32'hFFFF_FFF0; vb = 32'd7;
    chk(mem[32], 32'd0, "R11", "write to register 0 ignored");
    chk(mem[33], va + vb, "R10", "add result");
    chk(mem[34], va - vb, "R5", "sub result");
    chk(mem[35], 32'd1, "R5", "signed less-than");
    chk(mem[36], 32'd0, "R5", "unsigned less-than");
    chk(mem[37], va ^ vb, "R5", "xor result");
    chk(mem[38], ~(va | vb), "R5", "nor result");
    chk(mem[39], va & vb, "R5", "and result");
    chk(mem[40], va | vb, "R5", "or result");
    chk(mem[41], vb, "R11", "register 0 read as zero");
    chk(mem[50], 32'd0, "R6", "taken branch skipped store");
    chk(mem[16], va, "R12", "data word untouched");
    finish_run();
  end

endmodule